// File: doc/BRIEF.md
# Branch History Prediction Cache

This block is a small direct-mapped table that guesses the direction of conditional branches at fetch time. Each line keeps a valid flag, an address tag and the two most recent resolved directions of the branch that owns it. The fetch stage presents a program counter on the lookup port. One cycle later the block reports whether the line matched, and gives a taken or not-taken guess. When a line does not match, the guess is the static default, taken.

When a branch resolves, the execute stage presents its address and actual direction on the update port. A matching line shifts the new direction into its history. A line that does not match is claimed for the new branch, and both history bits are seeded with the resolved direction. The guess is read off the two-outcome pattern and not from a counter. Two equal outcomes repeat. Two different outcomes are taken to alternate, so the older of the two is predicted next.

Top module: `bhp_cache`

## Requirements
- R1: A synchronous active-high reset invalidates every line and drives `pd_valid`, `pd_hit` and `pd_taken` low. An update presented during reset leaves no valid line behind.
- R2: A lookup accepted at a clock edge (`lk_req` high) gives `pd_valid` high after that edge. A cycle with `lk_req` low gives `pd_valid` low after its edge.
- R3: `pd_hit` is 1 only when the indexed line is valid and its tag equals the lookup tag. A different tag at the same index gives a miss.
- R4: On a miss `pd_taken` is 1 (taken).
- R5: With history bits (older, recent) equal, the guess is that outcome: taken,taken gives 1 and not-taken,not-taken gives 0.
- R6: Older taken with recent not-taken predicts taken (1). Older not-taken with recent taken predicts not-taken (0).
- R7: An update that hits moves the old recent outcome into the older slot and writes the new outcome (`up_taken`, 1 = taken) into the recent slot.
- R8: An update that misses sets the line valid, writes its tag, and sets both history bits to `up_taken`. This replaces any other branch that held the line.
- R9: When a lookup and an update meet at the same line in the same cycle, the lookup reports the state from before the update.
- R10: With 16 lines, the index is PC bits [5:2] and the tag is PC bits [31:6]. PC bits [1:0] have no effect, and each of the 16 indices holds its own line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | 32 | Fetch address to look up |
| up_req | input | 1 | Update request |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| pd_valid | output | 1 | Lookup result present |
| pd_hit | output | 1 | Matching valid line found |
| pd_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
Several properties are checked on every cycle. `pd_valid` tracks the previous cycle's request, and a miss always reports taken. A matching update leaves the shifted history in the line. A non-matching update leaves a valid line holding the new tag and a seeded history. The bench's scenarios cover the rest: the alternation table across successive updates, eviction of a tag by another at the same index, the pre-update read when a lookup and an update collide, the independence of all sixteen indices, and a randomized mix of lookups and updates checked against a reference model.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  // Two-outcome history of one branch, 1 = taken.
  typedef struct packed {
    logic recent;
    logic older;
  } hist_t;

  // Guess from the outcome pattern: equal outcomes repeat,
  // different outcomes are assumed to keep alternating.
  function automatic logic hist_guess(input hist_t h);
    logic g;
    unique case ({h.older, h.recent})
      2'b11:   g = 1'b1;
      2'b00:   g = 1'b0;
      2'b10:   g = 1'b1;
      default: g = 1'b0;
    endcase
    return g;
  endfunction

  // History after a resolved outcome on a matching line.
  function automatic hist_t hist_shift(input hist_t h, input logic outcome);
    hist_t n;
    n.recent = outcome;
    n.older  = h.recent;
    return n;
  endfunction

  // History for a freshly claimed line.
  function automatic hist_t hist_seed(input logic outcome);
    hist_t n;
    n.recent = outcome;
    n.older  = outcome;
    return n;
  endfunction

endpackage

// File: rtl/bhp_addr_split.sv
module bhp_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFS_W = 2,
  localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  logic unused_ofs;

  assign idx        = pc[OFS_W +: IDX_W];
  assign tag        = pc[PC_W-1 -: TAG_W];
  assign unused_ofs = ^pc[OFS_W-1:0];

endmodule

// File: rtl/bhp_table.sv
module bhp_table
  import bhp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_req,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output hist_t            rd_hist
);

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem  [DEPTH];
  hist_t            hist_mem [DEPTH];

  logic  up_hit;
  hist_t up_old;
  hist_t up_new;

  assign up_old = hist_mem[up_idx];
  assign up_hit = valid_q[up_idx] && (tag_mem[up_idx] == up_tag);
  assign up_new = up_hit ? hist_shift(up_old, up_taken) : hist_seed(up_taken);

  // Valid flags live in flops so that reset can clear them all at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (up_req) begin
      valid_q[up_idx] <= 1'b1;
    end
  end

  // Tag and history arrays carry no reset, so they map onto plain RAM.
  always_ff @(posedge clk) begin
    if (up_req) begin
      tag_mem[up_idx]  <= up_tag;
      hist_mem[up_idx] <= up_new;
    end
  end

  // Read side for lookup; the result stage registers it.
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_hist  = hist_mem[rd_idx];

  // R1
  valid_clear_chk: assert property (@(posedge clk) $past(rst) |-> valid_q == '0);

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    up_req && up_hit |=>
      hist_mem[$past(up_idx)].recent == $past(up_taken) &&
      hist_mem[$past(up_idx)].older  == $past(up_old.recent));

  // R8
  alloc_line_chk: assert property (@(posedge clk) disable iff (rst)
    up_req && !up_hit |=>
      valid_q[$past(up_idx)] &&
      tag_mem[$past(up_idx)] == $past(up_tag) &&
      hist_mem[$past(up_idx)].recent == $past(up_taken) &&
      hist_mem[$past(up_idx)].older  == $past(up_taken));

endmodule

// File: rtl/bhp_result_reg.sv
module bhp_result_reg
  import bhp_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  hist_t            rd_hist,
  output logic             pd_valid,
  output logic             pd_hit,
  output logic             pd_taken
);

  logic match;
  logic guess;

  assign match = rd_valid && (rd_tag == lk_tag);
  assign guess = match ? hist_guess(rd_hist) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_valid <= 1'b0;
      pd_hit   <= 1'b0;
      pd_taken <= 1'b0;
    end else begin
      pd_valid <= lk_req;
      if (lk_req) begin
        pd_hit   <= match;
        pd_taken <= guess;
      end
    end
  end

  // R1
  out_reset_chk: assert property (@(posedge clk) $past(rst) |-> !pd_valid && !pd_hit && !pd_taken);

  // R2
  req_to_valid_chk: assert property (@(posedge clk) disable iff (rst) lk_req |=> pd_valid);

  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst) !lk_req |=> !pd_valid);

  // R4
  miss_taken_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req && !(rd_valid && rd_tag == lk_tag) |=> pd_taken && !pd_hit);

endmodule

// File: rtl/bhp_cache.sv
module bhp_cache
  import bhp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_req,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            up_req,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  output logic            pd_valid,
  output logic            pd_hit,
  output logic            pd_taken
);

  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag, rd_tag;
  logic             rd_valid;
  hist_t            rd_hist;

  bhp_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_lk_split (
    .pc (lk_pc),
    .idx(lk_idx),
    .tag(lk_tag)
  );

  bhp_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_up_split (
    .pc (up_pc),
    .idx(up_idx),
    .tag(up_tag)
  );

  bhp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .up_req  (up_req),
    .up_idx  (up_idx),
    .up_tag  (up_tag),
    .up_taken(up_taken),
    .rd_idx  (lk_idx),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_hist (rd_hist)
  );

  bhp_result_reg #(.TAG_W(TAG_W)) u_result (
    .clk     (clk),
    .rst     (rst),
    .lk_req  (lk_req),
    .lk_tag  (lk_tag),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_hist (rd_hist),
    .pd_valid(pd_valid),
    .pd_hit  (pd_hit),
    .pd_taken(pd_taken)
  );

endmodule

// File: tb/test_bhp_cache.sv
`timescale 1ns/1ps
module test_bhp_cache;

  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int OFS_W = 2;
  localparam int N     = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            lk_req = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            up_req = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic            up_taken = 1'b0;
  logic            pd_valid, pd_hit, pd_taken;

  always #2.5 clk = ~clk;

  bhp_cache #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) i_bhp_cache (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_pc(lk_pc),
    .up_req(up_req), .up_pc(up_pc), .up_taken(up_taken),
    .pd_valid(pd_valid), .pd_hit(pd_hit), .pd_taken(pd_taken)
  );

  // Reference model built from the requirements.
  bit               m_v   [N];
  logic [TAG_W-1:0] m_tag [N];
  logic             m_rec [N];
  logic             m_old [N];

  logic [1:0] exp_q [$];
  string      tag_q [$];
  int total = 0;
  int bad   = 0;
  logic [1:0] mon_e;
  string      mon_t;

  task automatic chk(input string tg, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tg, act, exp, $time);
    end
  endtask

  // Monitor: pops one expectation per reported result.
  always @(negedge clk) begin
    if (!rst && pd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 actual=unexpected result expected=none at %0t", $time);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk(mon_t, {pd_hit, pd_taken}, mon_e);
      end
    end
  end

  // Driver: one cycle of stimulus; expectation uses the pre-update model (R9).
  task automatic cyc(input bit lk, input logic [PC_W-1:0] lpc,
                     input bit up, input logic [PC_W-1:0] upc,
                     input logic ut, input string tg);
    if (lk) begin
      int i = int'((lpc >> OFS_W) & (N - 1));
      logic [TAG_W-1:0] t = lpc[PC_W-1 -: TAG_W];
      bit h = m_v[i] && (m_tag[i] == t);
      exp_q.push_back({h, h ? m_old[i] : 1'b1});
      tag_q.push_back(tg);
    end
    if (up) begin
      int j = int'((upc >> OFS_W) & (N - 1));
      logic [TAG_W-1:0] u = upc[PC_W-1 -: TAG_W];
      if (m_v[j] && m_tag[j] == u) begin
        m_old[j] = m_rec[j];
        m_rec[j] = ut;
      end else begin
        m_v[j] = 1'b1; m_tag[j] = u; m_rec[j] = ut; m_old[j] = ut;
      end
    end
    lk_req = lk; lk_pc = lpc; up_req = up; up_pc = upc; up_taken = ut;
    @(negedge clk);
    lk_req = 1'b0; up_req = 1'b0;
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string tg);
    cyc(1'b1, pc, 1'b0, '0, 1'b0, tg);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic ut);
    cyc(1'b0, '0, 1'b1, pc, ut, "none");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) m_v[k] = 1'b0;
    // Update during reset must leave nothing valid (R1).
    @(negedge clk);
    up_req = 1'b1; up_pc = 32'h0000_0300; up_taken = 1'b0;
    repeat (3) @(negedge clk);
    up_req = 1'b0;
    rst = 1'b0;
    chk("R1", {pd_valid, pd_hit}, 2'b00);
    chk("R1", {1'b0, pd_taken}, 2'b00);
    look(32'h0000_0300, "R1");

    // Miss gives taken (R4), allocation seeds history (R8).
    look(32'h0000_0100, "R4");
    upd(32'h0000_0100, 1'b0);
    look(32'h0000_0100, "R8");
    // Shift and the alternation table (R7, R6, R5).
    upd(32'h0000_0100, 1'b1);
    look(32'h0000_0100, "R6");
    upd(32'h0000_0100, 1'b1);
    look(32'h0000_0100, "R5");
    upd(32'h0000_0100, 1'b0);
    look(32'h0000_0100, "R6");
    upd(32'h0000_0100, 1'b0);
    look(32'h0000_0100, "R5");
    upd(32'h0000_0100, 1'b1);
    look(32'h0000_0100, "R7");

    // Same index, other tag (R3), eviction (R8), byte offsets ignored (R10).
    look(32'h0000_0140, "R3");
    upd(32'h0000_0140, 1'b0);
    look(32'h0000_0100, "R3");
    look(32'h0000_0143, "R10");
    look(32'h0000_0141, "R10");

    // Idle cycle produces no result (R2).
    look(32'h0000_0140, "R2");
    cyc(1'b0, '0, 1'b0, '0, 1'b0, "none");
    chk("R2", {1'b0, pd_valid}, 2'b00);

    // Collision of lookup and update on one line (R9).
    cyc(1'b1, 32'h0000_0208, 1'b1, 32'h0000_0208, 1'b0, "R9");
    look(32'h0000_0208, "R9");
    cyc(1'b1, 32'h0000_0208, 1'b1, 32'h0000_0208, 1'b1, "R9");
    look(32'h0000_0208, "R9");

    // Every index keeps its own line (R10).
    for (int k = 0; k < N; k++) upd(32'h0000_1000 + k * 4, k[0]);
    for (int k = 0; k < N; k++) upd(32'h0000_1000 + k * 4, k[1]);
    for (int k = 0; k < N; k++) look(32'h0000_1000 + k * 4, "R10");

    // Randomized mix against the model (R3, R5, R6, R7).
    for (int n = 0; n < 400; n++) begin
      logic [PC_W-1:0] a = {22'd0, 2'($urandom % 3), 4'($urandom), 2'd0, 2'($urandom)};
      logic [PC_W-1:0] b = {22'd0, 2'($urandom % 3), 4'($urandom), 2'd0, 2'($urandom)};
      cyc(1'($urandom), a, 1'($urandom), b, 1'($urandom), "R7");
    end

    repeat (3) @(negedge clk);
    chk("R2", {1'b0, exp_q.size() != 0}, 2'b00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule